// File: doc/BRIEF.md
# Digital Potentiometer Register Controller

This block keeps the control state of a single-channel digital potentiometer. A host reaches it through a byte-wide request port. Each request carries a 7-bit device address, a 2-bit register index, a write flag and a data byte.

The wiper position is a 7-bit code:
- 00h is the tap nearest the low terminal.
- 7Fh is the tap nearest the high terminal.
- Positions in between rise steadily with the code.

Two of the registers stand in for nonvolatile cells:
- the stored start position;
- the mode selection.

A write to either of them raises a busy flag for a programmable number of clocks. This models the cell write time. While the flag is up, every write is refused.

Power-up happens in two steps:
1. While the power-good input is low, the wiper is held at midscale (40h).
2. On the first clock with power-good high, the wiper reloads from the stored start position.

Requests are held off until the reload is done.

The request side follows valid/ready rules:
- A request transfers on a clock where `req_valid` and `req_ready` are both high.
- `req_ready` is low only while power is not good and for the reload clock.
- While `req_ready` is low, the host must hold its request steady.

The read response is a one-cycle `rsp_valid` pulse with data. It cannot be stalled, so the host must take it on that cycle.

Top module: `dpot_regs`

## Requirements
- R1: While `pwr_good` is low, `wiper` is 40h and `req_ready` is low. After reset the stored start position is 40h, VOL is 0, SHDN is 1, and both mode bits are 0.
- R2: On the first clock edge that samples `pwr_good` high, `wiper` takes the stored start position. `req_ready` is high from the following cycle.
- R3: A request whose device address differs from 50h, or from 54h when `addr_strap` is 1, is accepted. It changes no state and produces no response.
- R4: With VOL=0, a write to register 0 stores data bits 6:0 both as the start position and as the wiper code, and it starts a busy period. A read of register 0 returns the start position, with bit 7 reading 0.
- R5: With VOL=1, a write to register 0 changes only the wiper code and starts no busy period. A read of register 0 returns the wiper code.
- R6: Register 2 has VOL at bit 7 and SHDN at bit 6. `shutdown` is high when SHDN is 0. A read returns the busy flag in bit 5 and zeros in bits 4:0.
- R7: Register 1 has the divider-mode bit at bit 7 and precision-off at bit 6, and drives `divider_mode` and `precision_off`. Bits 5:0 read 0. A write to it starts a busy period.
- R8: `nv_busy` is high for exactly NV_CYCLES clocks after the edge that accepts a write to a nonvolatile register.
- R9: Every write accepted while `nv_busy` is high is ignored. Reads are still served and show current contents.
- R10: A read response arrives on the cycle after acceptance. Register 3 reads 00h and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Supply good enough for nonvolatile reads |
| addr_strap | input | 1 | Selects device address 50h (0) or 54h (1) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts requests |
| req_write | input | 1 | 1 for write, 0 for read |
| req_dev | input | 7 | Device address of the request |
| req_reg | input | 2 | Register index |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | 8 | Read data |
| wiper | output | 7 | Current wiper code |
| shutdown | output | 1 | Potentiometer shut down |
| divider_mode | output | 1 | 1 for voltage divider, 0 for rheostat |
| precision_off | output | 1 | Precision matching disabled |
| nv_busy | output | 1 | Nonvolatile write in progress |

## Verification
The bench builds the block with NV_CYCLES=5, down from the default of 2000, and with the default 7-bit wiper and device base 50h. The short busy window lets random traffic land writes both inside and just after a busy period. It also lets the bench check the exact busy length many times within a short run. The strap is switched during the run, so both device addresses and the rejection of the other one are exercised. The bench also drops power-good after programming a stored position, to show the midscale hold and the reload.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  typedef enum logic [1:0] {
    REG_POS  = 2'd0,
    REG_MODE = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } reg_idx_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/dpot_powerup.sv
module dpot_powerup (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic ready,
  output logic hold,
  output logic load
);
  logic ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= pwr_good;
  end

  assign ready = ready_q;
  assign hold  = !pwr_good;
  assign load  = pwr_good && !ready_q;

  // R2
  ready_after_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> $past(pwr_good));
  // R1
  not_ready_without_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> !ready);
endmodule

// File: rtl/dpot_nvtimer.sv
module dpot_nvtimer #(
  parameter int CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (start)     cnt <= CW'(CYCLES);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R8
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R8
  idle_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
endmodule

// File: rtl/dpot_regfile.sv
module dpot_regfile
  import dpot_pkg::*;
#(
  parameter int WIPER_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              load,
  input  logic              wr_en,
  input  logic              rd_en,
  input  reg_idx_e          sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              busy,
  output logic              nv_start,
  output logic [WIPER_W-1:0] wiper,
  output logic              vol,
  output logic              shdn_n,
  output logic              mode_div,
  output logic              prec_off,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data
);
  localparam logic [WIPER_W-1:0] MID = WIPER_W'(1) << (WIPER_W - 1);
  localparam int PAD = BYTE_W - WIPER_W;

  logic [WIPER_W-1:0] ivr;
  logic [WIPER_W-1:0] pos_q;
  logic               wr_ok;
  logic [BYTE_W-1:0]  rd_mux;

  assign wr_ok    = wr_en && !busy;
  assign nv_start = wr_ok && ((sel == REG_POS && !vol) || sel == REG_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivr      <= MID;
      pos_q    <= MID;
      vol      <= 1'b0;
      shdn_n   <= 1'b1;
      mode_div <= 1'b0;
      prec_off <= 1'b0;
    end else begin
      if (wr_ok) begin
        case (sel)
          REG_POS: begin
            pos_q <= wdata[WIPER_W-1:0];
            if (!vol) ivr <= wdata[WIPER_W-1:0];
          end
          REG_MODE: begin
            mode_div <= wdata[7];
            prec_off <= wdata[6];
          end
          REG_CTRL: begin
            vol    <= wdata[7];
            shdn_n <= wdata[6];
          end
          default: ;
        endcase
      end
      if (hold)      pos_q <= MID;
      else if (load) pos_q <= ivr;
    end
  end

  always_comb begin
    case (sel)
      REG_POS:  rd_mux = {{PAD{1'b0}}, (vol ? pos_q : ivr)};
      REG_MODE: rd_mux = {mode_div, prec_off, 6'b0};
      REG_CTRL: rd_mux = {vol, shdn_n, busy, 5'b0};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  assign wiper = pos_q;

  // R9
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> ($stable(ivr) && $stable(mode_div) && $stable(prec_off)
                         && $stable(vol) && $stable(shdn_n)));
  // R1
  hold_midscale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (wiper == MID));
  // R2
  reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr_en) |=> (wiper == $past(ivr)));
  // R10
  read_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
endmodule

// File: rtl/dpot_regs.sv
module dpot_regs
  import dpot_pkg::*;
#(
  parameter int         WIPER_W   = 7,
  parameter int         DEV_W     = 7,
  parameter logic [6:0] DEV_BASE  = 7'h50,
  parameter int         STRAP_BIT = 2,
  parameter int         NV_CYCLES = 2000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwr_good,
  input  logic         addr_strap,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic         req_write,
  input  logic [DEV_W-1:0] req_dev,
  input  logic [1:0]   req_reg,
  input  logic [7:0]   req_wdata,
  output logic         rsp_valid,
  output logic [7:0]   rsp_data,
  output logic [WIPER_W-1:0] wiper,
  output logic         shutdown,
  output logic         divider_mode,
  output logic         precision_off,
  output logic         nv_busy
);
  logic [DEV_W-1:0] dev_addr;
  logic match, accept, wr_en, rd_en;
  logic hold, load, nv_start, vol, shdn_n;

  assign dev_addr = DEV_W'(DEV_BASE) | (DEV_W'(addr_strap) << STRAP_BIT);
  assign match    = (req_dev == dev_addr);
  assign accept   = req_valid && req_ready && match;
  assign wr_en    = accept && req_write;
  assign rd_en    = accept && !req_write;

  dpot_powerup u_pwr (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .ready(req_ready), .hold(hold), .load(load)
  );

  dpot_nvtimer #(.CYCLES(NV_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(nv_start), .busy(nv_busy)
  );

  dpot_regfile #(.WIPER_W(WIPER_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .hold(hold), .load(load),
    .wr_en(wr_en), .rd_en(rd_en), .sel(reg_idx_e'(req_reg)),
    .wdata(req_wdata), .busy(nv_busy), .nv_start(nv_start),
    .wiper(wiper), .vol(vol), .shdn_n(shdn_n),
    .mode_div(divider_mode), .prec_off(precision_off),
    .rd_valid(rsp_valid), .rd_data(rsp_data)
  );

  assign shutdown = !shdn_n;

  // R3
  foreign_dev_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !match) |=> !rsp_valid);
  // R3
  foreign_dev_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !match && !nv_busy) |=> !nv_busy);
endmodule

// File: tb/sim_dpot_regs.sv
`timescale 1ns/1ps
module sim_dpot_regs;
  localparam int N = 5;

  logic clk = 0, rst_n = 0, pwr_good = 0, addr_strap = 0;
  logic req_valid = 0, req_write = 0;
  logic [6:0] req_dev = 0;
  logic [1:0] req_reg = 0;
  logic [7:0] req_wdata = 0;
  logic req_ready, rsp_valid, shutdown, divider_mode, precision_off, nv_busy;
  logic [7:0] rsp_data;
  logic [6:0] wiper;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [6:0] m_ivr = 7'h40, m_wr = 7'h40;
  bit m_vol = 0, m_shdn = 1, m_mode = 0, m_prec = 0, m_ready = 0;
  int m_busy = 0;

  always #4 clk = ~clk;

  dpot_regs #(.NV_CYCLES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .addr_strap(addr_strap),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_dev(req_dev), .req_reg(req_reg), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .wiper(wiper),
    .shutdown(shutdown), .divider_mode(divider_mode),
    .precision_off(precision_off), .nv_busy(nv_busy)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] my_dev();
    return addr_strap ? 7'h54 : 7'h50;
  endfunction

  function automatic logic [7:0] rd_model(logic [1:0] r);
    case (r)
      2'd0: return {1'b0, (m_vol ? m_wr : m_ivr)};
      2'd1: return {m_mode, m_prec, 6'b0};
      2'd2: return {m_vol, m_shdn, (m_busy != 0), 5'b0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check_outs();
    chk("R4/R5 wiper", wiper, m_wr);
    chk("R8 busy", nv_busy, (m_busy != 0));
    chk("R6 shutdown", shutdown, !m_shdn);
    chk("R7 divider", divider_mode, m_mode);
    chk("R7 precision", precision_off, m_prec);
    chk("R1/R2 ready", req_ready, m_ready);
  endtask

  // called at a negedge
  task automatic step(bit v, bit w, logic [6:0] dev, logic [1:0] r, logic [7:0] d);
    bit acc, start;
    logic [7:0] exp_rd;
    acc = v && m_ready && (dev == my_dev());
    exp_rd = rd_model(r);
    start = 0;
    req_valid = v; req_write = w; req_dev = dev; req_reg = r; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    if (acc && w && m_busy == 0) begin
      case (r)
        2'd0: begin m_wr = d[6:0]; if (!m_vol) begin m_ivr = d[6:0]; start = 1; end end
        2'd1: begin m_mode = d[7]; m_prec = d[6]; start = 1; end
        2'd2: begin m_vol = d[7]; m_shdn = d[6]; end
        default: ;
      endcase
    end
    if (!pwr_good) m_wr = 7'h40;
    else if (!m_ready) m_wr = m_ivr;
    m_ready = pwr_good;
    if (start) m_busy = N;
    else if (m_busy > 0) m_busy--;
    req_valid = 0;
    chk("R10 rsp_valid", rsp_valid, acc && !w);
    if (acc && !w) chk("R10 rsp_data", rsp_data, exp_rd);
    check_outs();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 7'h50, 2'd0, 8'h00);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset wiper", wiper, 7'h40);
    chk("R1 reset ready", req_ready, 0);
    rst_n = 1;
    idle(3);
    step(1, 1, 7'h50, 2'd0, 8'h11); // R1 not accepted while power low
    pwr_good = 1;
    idle(2);                          // R2 reload
    step(1, 0, 7'h50, 2'd2, 8'h00);   // R6 reset ctrl = 40h
    step(1, 0, 7'h50, 2'd1, 8'h00);   // R7 reset mode = 0
    step(1, 1, 7'h50, 2'd0, 8'h95);   // R4 nv write
    step(1, 1, 7'h50, 2'd2, 8'hC0);   // R9 rejected while busy
    step(1, 0, 7'h50, 2'd0, 8'h00);   // R9 read during busy
    step(1, 0, 7'h50, 2'd2, 8'h00);   // R6 busy bit visible
    idle(4);                          // R8 busy ends
    step(1, 1, 7'h50, 2'd2, 8'hC0);   // R6 vol=1
    step(1, 1, 7'h50, 2'd0, 8'h7F);   // R5 volatile only
    step(1, 0, 7'h50, 2'd0, 8'h00);   // R5 read wiper
    step(1, 1, 7'h50, 2'd2, 8'h00);   // R6 vol=0, shutdown
    step(1, 0, 7'h50, 2'd0, 8'h00);   // R4 read ivr
    step(1, 1, 7'h50, 2'd1, 8'hFF);   // R7 mode write
    step(1, 1, 7'h50, 2'd1, 8'h00);   // R9 rejected
    step(1, 0, 7'h50, 2'd1, 8'h00);   // R7 read C0
    idle(5);
    step(1, 1, 7'h50, 2'd3, 8'hFF);   // R10 reg3 write ignored
    step(1, 0, 7'h50, 2'd3, 8'h00);   // R10 reg3 reads 0
    step(1, 1, 7'h54, 2'd2, 8'h40);   // R3 foreign device
    step(1, 0, 7'h54, 2'd2, 8'h00);   // R3 no response
    addr_strap = 1;
    step(1, 1, 7'h54, 2'd2, 8'h40);   // R3 strap address
    step(1, 1, 7'h50, 2'd2, 8'h00);   // R3 old address ignored
    step(1, 0, 7'h54, 2'd2, 8'h00);
    // power cycle: R1 hold, R2 reload of stored 15h
    pwr_good = 0;
    idle(3);
    pwr_good = 1;
    idle(2);
    chk("R2 reload wiper", wiper, 7'h15);
    begin
      int unsigned seed;
      seed = $urandom(32'd1234);
      for (int i = 0; i < 600; i++) begin
        int unsigned rv;
        rv = $urandom;
        if (i % 150 == 149) addr_strap = ~addr_strap;
        step(rv[0] | rv[1], rv[2], (rv[5:3] == 0) ? (my_dev() ^ 7'h04) : my_dev(),
             rv[7:6], rv[15:8]);
      end
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule